// File: doc/BRIEF.md
# Partial-Width General-Purpose Register File

This block holds eight 32-bit general-purpose registers behind two combinational read ports and one synchronous write port. Every port can access a register at full width, as its low 16-bit half, or, for the first four registers, as either of the two bytes that make up that low half. Narrow reads come back zero-extended to 32 bits. A narrow write replaces only the bits it addresses and leaves the rest of the register intact, so the 16-bit and byte views are aliases of the same storage.

A port selects a register with a 3-bit index and an access width with a 3-bit size code. Byte accesses also need a high/low select. Any access that the addressed register cannot support is reported on a per-port illegal flag. An illegal write changes nothing. The block is meant to sit between an instruction decoder and an execution unit. Results are written back at the clock edge, and reads in the same cycle return the value held before that edge.

Top module: `partial_regfile`

## Requirements
- R1: With the synchronous active-low reset asserted at a clock edge, every register reads as zero at full width afterwards.
- R2: A write with size code 4 (long) replaces all 32 bits of any of the eight registers, and a long read returns all 32 bits.
- R3: A write with size code 2 (word) replaces bits 15..0 of the addressed register with write data bits 15..0, and bits 31..16 keep their previous value.
- R4: A write with size code 1 (byte) to register 0..3 stores write data bits 7..0 into bits 7..0 when the high select is 0, or into bits 15..8 when it is 1. All other bits keep their previous value.
- R5: A word read returns register bits 15..0 in output bits 15..0. A byte read returns the selected byte (high select 0: bits 7..0, 1: bits 15..8) in output bits 7..0. All higher output bits are zero.
- R6: A byte access to registers 4..7, or any size code other than 1, 2 or 4, is illegal. An illegal read drives zero data with its illegal flag high. An illegal write with write enable high raises the write illegal flag and changes no register.
- R7: A read of the register being written in the same cycle returns the old value, and the new value is visible after the clock edge.
- R8: With write enable low, no register changes and the write illegal flag is low. A write never changes a register other than the addressed one.
- R9: The two read ports are independent, and each can read any register at any legal width in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Register index for the write |
| wr_size | input | 3 | Write size code: 1 byte, 2 word, 4 long |
| wr_hi | input | 1 | Byte write targets bits 15..8 when set |
| wr_data | input | 32 | Write data, low-aligned for narrow writes |
| wr_illegal | output | 1 | Write request is illegal and was dropped |
| rd0_idx | input | 3 | Register index, read port 0 |
| rd0_size | input | 3 | Size code, read port 0 |
| rd0_hi | input | 1 | High byte select, read port 0 |
| rd0_data | output | 32 | Zero-extended read data, port 0 |
| rd0_illegal | output | 1 | Read request on port 0 is illegal |
| rd1_idx | input | 3 | Register index, read port 1 |
| rd1_size | input | 3 | Size code, read port 1 |
| rd1_hi | input | 1 | High byte select, read port 1 |
| rd1_data | output | 32 | Zero-extended read data, port 1 |
| rd1_illegal | output | 1 | Read request on port 1 is illegal |

## Verification
On every cycle the assertions check that narrow and illegal reads carry no stray upper bits. They also check that a word or byte write leaves the bits outside its lane untouched, that an illegal or disabled write leaves every register stable, and that no write disturbs a register it does not address. The bench scenarios are needed for the rest. They show that the correct lane receives the correct data, that reset clears storage, that a same-cycle read sees the old contents, and that the two ports return distinct registers at the same time. Those scenarios sweep every index, size code and byte select against an arithmetic model.

// File: rtl/prf_pkg.sv
// Package prf_pkg
// Holds the size-code encoding and the legality rule shared by the read
// views and the write merge of the partial register file.
// Assumes a 3-bit size code where 1, 2 and 4 name byte, word and long.
package prf_pkg;
    localparam int SIZE_W = 3;
    localparam logic [SIZE_W-1:0] SZ_BYTE = 3'd1;
    localparam logic [SIZE_W-1:0] SZ_WORD = 3'd2;
    localparam logic [SIZE_W-1:0] SZ_LONG = 3'd4;

    // Legal when the width is long or word, or byte on a byte-capable register.
    function automatic logic access_ok(input logic byte_cap, input logic [SIZE_W-1:0] size);
        case (size)
            SZ_LONG, SZ_WORD: access_ok = 1'b1;
            SZ_BYTE:          access_ok = byte_cap;
            default:          access_ok = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/prf_read_view.sv
// Module prf_read_view
// Turns one full register value into the zero-extended view that a read
// port asked for, and flags illegal requests (data is then zero).
// Assumes the register value is already selected by index in the caller.
// The clock and reset are used only by the local assertions.
module prf_read_view #(
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 3,
    parameter int BYTE_REGS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           idx,
    input  logic [prf_pkg::SIZE_W-1:0] size,
    input  logic                       hi,
    input  logic [DATA_W-1:0]          reg_val,
    output logic [DATA_W-1:0]          data,
    output logic                       illegal
);
    import prf_pkg::*;
    localparam int HALF_W = DATA_W / 2;
    localparam int BYTE_W = DATA_W / 4;

    logic byte_cap;
    logic legal;

    // Decide whether the addressed register offers the requested width.
    always_comb begin
        byte_cap = ({1'b0, idx} < (IDX_W+1)'(BYTE_REGS));
        legal    = access_ok(byte_cap, size);
    end

    // Extract and zero-extend the requested lane.
    always_comb begin
        data = '0;
        if (legal) begin
            case (size)
                SZ_LONG: data = reg_val;
                SZ_WORD: data = DATA_W'(reg_val[HALF_W-1:0]);
                SZ_BYTE: data = hi ? DATA_W'(reg_val[2*BYTE_W-1:BYTE_W])
                                   : DATA_W'(reg_val[BYTE_W-1:0]);
                default: data = '0;
            endcase
        end
        illegal = !legal;
    end

    // R5: word reads carry nothing above bit 15.
    assert_word_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_WORD) |-> (data[DATA_W-1:HALF_W] == '0));
    // R5: byte reads carry nothing above bit 7.
    assert_byte_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_BYTE) |-> (data[DATA_W-1:BYTE_W] == '0));
    // R6: an illegal read returns zero data.
    assert_illegal_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (data == '0));
endmodule

// File: rtl/prf_write_merge.sv
// Module prf_write_merge
// Builds the next value of the addressed register by overlaying the write
// data onto its old contents in the requested lane only.
// Assumes low-aligned write data; reports legality of the write request.
module prf_write_merge #(
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 3,
    parameter int BYTE_REGS = 4
) (
    input  logic [IDX_W-1:0]           idx,
    input  logic [prf_pkg::SIZE_W-1:0] size,
    input  logic                       hi,
    input  logic [DATA_W-1:0]          old_val,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          new_val,
    output logic                       legal
);
    import prf_pkg::*;
    localparam int HALF_W = DATA_W / 2;
    localparam int BYTE_W = DATA_W / 4;

    logic byte_cap;

    // Decide whether the addressed register accepts this write width.
    always_comb begin
        byte_cap = ({1'b0, idx} < (IDX_W+1)'(BYTE_REGS));
        legal    = access_ok(byte_cap, size);
    end

    // Overlay the write data onto the old value in the chosen lane.
    always_comb begin
        new_val = old_val;
        case (size)
            SZ_LONG: new_val = wdata;
            SZ_WORD: new_val[HALF_W-1:0] = wdata[HALF_W-1:0];
            SZ_BYTE: begin
                if (hi) new_val[2*BYTE_W-1:BYTE_W] = wdata[BYTE_W-1:0];
                else    new_val[BYTE_W-1:0]        = wdata[BYTE_W-1:0];
            end
            default: new_val = old_val;
        endcase
    end
endmodule

// File: rtl/partial_regfile.sv
// Module partial_regfile
// Register file with two combinational read ports and one write port,
// each able to access full, low-half or byte views of a register.
// Assumes synchronous active-low reset; reads return pre-edge contents.
module partial_regfile #(
    parameter int NUM_REGS  = 8,
    parameter int DATA_W    = 32,
    parameter int BYTE_REGS = 4,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [prf_pkg::SIZE_W-1:0] wr_size,
    input  logic                       wr_hi,
    input  logic [DATA_W-1:0]          wr_data,
    output logic                       wr_illegal,
    input  logic [IDX_W-1:0]           rd0_idx,
    input  logic [prf_pkg::SIZE_W-1:0] rd0_size,
    input  logic                       rd0_hi,
    output logic [DATA_W-1:0]          rd0_data,
    output logic                       rd0_illegal,
    input  logic [IDX_W-1:0]           rd1_idx,
    input  logic [prf_pkg::SIZE_W-1:0] rd1_size,
    input  logic                       rd1_hi,
    output logic [DATA_W-1:0]          rd1_data,
    output logic                       rd1_illegal
);
    import prf_pkg::*;
    localparam int HALF_W = DATA_W / 2;
    localparam int BYTE_W = DATA_W / 4;

    logic [DATA_W-1:0] q [NUM_REGS];
    logic [DATA_W-1:0] merged;
    logic              wr_legal;
    logic              wr_commit;

    prf_write_merge #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BYTE_REGS(BYTE_REGS)) u_merge (
        .idx     (wr_idx),
        .size    (wr_size),
        .hi      (wr_hi),
        .old_val (q[wr_idx]),
        .wdata   (wr_data),
        .new_val (merged),
        .legal   (wr_legal)
    );

    // Qualify the write request and report a dropped illegal request.
    always_comb begin
        wr_commit  = wr_en && wr_legal;
        wr_illegal = wr_en && !wr_legal;
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // Hold one register; clear on reset, load the merged value on commit.
        always_ff @(posedge clk) begin
            if (!rst_n)                                      q[i] <= '0;
            else if (wr_commit && (wr_idx == IDX_W'(i)))     q[i] <= merged;
        end

        // R3: a word write keeps the upper half.
        assert_word_keeps_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_commit && wr_idx == IDX_W'(i) && wr_size == SZ_WORD)
            |=> (q[i][DATA_W-1:HALF_W] == $past(q[i][DATA_W-1:HALF_W])));
        // R4: a low-byte write keeps bits above the low byte.
        assert_lo_byte_keeps_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_commit && wr_idx == IDX_W'(i) && wr_size == SZ_BYTE && !wr_hi)
            |=> (q[i][DATA_W-1:BYTE_W] == $past(q[i][DATA_W-1:BYTE_W])));
        // R4: a high-byte write keeps the low byte and the upper half.
        assert_hi_byte_keeps_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_commit && wr_idx == IDX_W'(i) && wr_size == SZ_BYTE && wr_hi)
            |=> (q[i][BYTE_W-1:0] == $past(q[i][BYTE_W-1:0]) &&
                 q[i][DATA_W-1:HALF_W] == $past(q[i][DATA_W-1:HALF_W])));
        // R6: an illegal write leaves every register as it was.
        assert_illegal_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
            wr_illegal |=> $stable(q[i]));
        // R8: a register not addressed by an enabled write stays stable.
        assert_unaddressed_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IDX_W'(i)) |=> $stable(q[i]));
    end

    prf_read_view #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BYTE_REGS(BYTE_REGS)) u_rd0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (rd0_idx),
        .size    (rd0_size),
        .hi      (rd0_hi),
        .reg_val (q[rd0_idx]),
        .data    (rd0_data),
        .illegal (rd0_illegal)
    );

    prf_read_view #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BYTE_REGS(BYTE_REGS)) u_rd1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (rd1_idx),
        .size    (rd1_size),
        .hi      (rd1_hi),
        .reg_val (q[rd1_idx]),
        .data    (rd1_data),
        .illegal (rd1_illegal)
    );

    // R8: no illegal flag without a write request.
    assert_no_flag_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !wr_illegal);
endmodule

// File: tb/partial_regfile_test.sv
`timescale 1ns/1ps
module partial_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [2:0]  wr_size = 3'd4;
    logic        wr_hi = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_illegal;
    logic [2:0]  rd0_idx = '0, rd1_idx = '0;
    logic [2:0]  rd0_size = 3'd4, rd1_size = 3'd4;
    logic        rd0_hi = 1'b0, rd1_hi = 1'b0;
    logic [31:0] rd0_data, rd1_data;
    logic        rd0_illegal, rd1_illegal;

    int checks = 0;
    int errors = 0;
    logic [31:0] m [8];

    partial_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_hi(wr_hi),
        .wr_data(wr_data), .wr_illegal(wr_illegal),
        .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_hi(rd0_hi),
        .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
        .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_hi(rd1_hi),
        .rd1_data(rd1_data), .rd1_illegal(rd1_illegal)
    );

    always #10 clk = ~clk;

    function automatic bit legal(input int idx, input int sz);
        return (sz == 4) || (sz == 2) || (sz == 1 && idx < 4);
    endfunction

    function automatic logic [31:0] view(input logic [31:0] v, input int idx, input int sz, input bit hi);
        if (!legal(idx, sz)) return 32'd0;
        if (sz == 4) return v;
        if (sz == 2) return v % 32'h10000;
        return (v >> (hi ? 8 : 0)) % 32'h100;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] v, input int idx, input int sz,
                                          input bit hi, input logic [31:0] d);
        logic [31:0] mask;
        int sh;
        if (!legal(idx, sz)) return v;
        if (sz == 4) return d;
        sh   = (sz == 1 && hi) ? 8 : 0;
        mask = ((sz == 2) ? 32'hFFFF : 32'hFF) << sh;
        return (v & ~mask) | ((d << sh) & mask);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one write for one clock edge and update the model.
    task automatic wr(input int idx, input int sz, input bit hi, input logic [31:0] d, input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_size = 3'(sz); wr_hi = hi; wr_data = d;
        #2 chk({req, " wr_illegal"}, 32'(wr_illegal), 32'(!legal(idx, sz)));
        @(posedge clk);
        m[idx] = merge(m[idx], idx, sz, hi, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int i0, input int s0, input bit h0, input int i1, input int s1,
                      input bit h1, input string req);
        @(negedge clk);
        rd0_idx = 3'(i0); rd0_size = 3'(s0); rd0_hi = h0;
        rd1_idx = 3'(i1); rd1_size = 3'(s1); rd1_hi = h1;
        #2;
        chk({req, " rd0_data"}, rd0_data, view(m[i0], i0, s0, h0));
        chk({req, " rd0_illegal"}, 32'(rd0_illegal), 32'(!legal(i0, s0)));
        chk({req, " rd1_data"}, rd1_data, view(m[i1], i1, s1, h1));
        chk({req, " rd1_illegal"}, 32'(rd1_illegal), 32'(!legal(i1, s1)));
    endtask

    task automatic read_all_long(input string req);
        for (int i = 0; i < 8; i++) rd(i, 4, 0, 7 - i, 4, 0, req);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m[i] = 32'd0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        read_all_long("R1 reset");

        // R2: full-width writes on every register.
        for (int i = 0; i < 8; i++) wr(i, 4, 0, 32'h9E3779B9 * (i + 1), "R2");
        read_all_long("R2 readback");

        // R5 R6 R9: sweep every index, size code and byte select on both ports.
        for (int i = 0; i < 8; i++)
            for (int s = 0; s < 8; s++)
                for (int h = 0; h < 2; h++)
                    rd(i, s, h[0], 7 - i, (s + 3) % 8, !h[0], "R5 R6 R9 sweep");

        // R3: word writes keep the upper half.
        for (int i = 0; i < 8; i++) wr(i, 2, 0, 32'hDEAD0000 | (i * 32'h1111), "R3");
        read_all_long("R3 readback");

        // R4 R6: byte writes on every register and lane.
        for (int i = 0; i < 8; i++)
            for (int h = 0; h < 2; h++) begin
                wr(i, 1, h[0], 32'hCAFE5A00 | (i * 16 + h), "R4 R6 byte");
                rd(i, 4, 0, i, 1, h[0], "R4 R6 byte readback");
            end
        read_all_long("R4 readback");

        // R6: unsupported size codes write nothing.
        wr(0, 3, 0, 32'hFFFFFFFF, "R6 size3");
        wr(5, 0, 1, 32'hFFFFFFFF, "R6 size0");
        wr(2, 7, 0, 32'hFFFFFFFF, "R6 size7");
        read_all_long("R6 readback");

        // R8: disabled write changes nothing and raises no flag.
        @(negedge clk);
        wr_en = 1'b0; wr_idx = 3'd3; wr_size = 3'd4; wr_data = 32'h0BADF00D;
        #2 chk("R8 idle flag", 32'(wr_illegal), 32'd0);
        @(posedge clk);
        read_all_long("R8 idle");

        // R7: same-cycle read sees old value; new value after the edge.
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd2; wr_size = 3'd4; wr_hi = 1'b0; wr_data = 32'h12345678;
        rd0_idx = 3'd2; rd0_size = 3'd4; rd0_hi = 1'b0;
        rd1_idx = 3'd2; rd1_size = 3'd2; rd1_hi = 1'b0;
        #2;
        chk("R7 old rd0", rd0_data, m[2]);
        chk("R7 old rd1", rd1_data, m[2] % 32'h10000);
        @(posedge clk);
        m[2] = 32'h12345678;
        #2;
        chk("R7 new rd0", rd0_data, 32'h12345678);
        chk("R7 new rd1", rd1_data, 32'h00005678);
        @(negedge clk) wr_en = 1'b0;

        // R1: reset in mid-run clears everything.
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < 8; i++) m[i] = 32'd0;
        read_all_long("R1 second reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule